// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Output and PWM Modes

This block is a free-running 8-bit counter with one compare channel and a waveform generator that drives a single output pin. The counter advances only on cycles where an external clock-enable tick is high, so a prescaler outside the block sets the count rate. Four counting modes are offered: a plain wrapping count, a count that clears on compare, single-slope PWM and dual-slope PWM.

Software reaches the block through a small write port and a combinational read port with four word addresses. Through these it selects the mode and the compare-output action, loads the counter and the compare value, fires a force strobe, and clears two sticky flags, overflow and compare, by writing ones. In the two PWM modes the compare value is buffered and copied to the working compare at the counter's top. In the two other modes it takes effect at once.

Top module: `pwm_timer`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the counter, the compare value, both flags, the control word and wave_o are all zero.
- R2: Register map: address 0 is control (bits 1:0 mode, where 0 = free count, 1 = clear-on-match, 2 = single-slope PWM, 3 = dual-slope PWM; bits 3:2 output action; bit 4 is a force strobe that reads back as 0), address 1 is the counter, address 2 is the compare value as written, and address 3 holds the flags (bit 0 overflow, bit 1 compare). In mode 0 the counter rises by one per tick, holds when tick is low, and wraps from 255 to 0, setting the overflow flag on that tick.
- R3: In mode 1 the tick that finds the counter equal to the compare value sets the compare flag and loads 0 into the counter. Outside the PWM modes a compare write takes effect on the next tick.
- R4: In mode 2 the counter counts 0 to 255 and wraps, setting the overflow flag at the wrap. Action 2 sets wave_o at the wrap and clears it at a match, so it is high for compare+1 of every 256 ticks. Action 3 gives the complement, and the wrap wins when both events fall on the same tick.
- R5: In mode 3 the counter rises to 255, turns and falls to 0, then turns and rises again (period 510 ticks). The overflow flag sets on the tick that turns the counter at 0.
- R6: In mode 3 with action 2, a match while rising clears wave_o and a match while falling sets it, so wave_o is high for 2*compare ticks of each period.
- R7: Action 1 toggles wave_o on every match in every mode. With action 0, wave_o holds its last value.
- R8: In modes 2 and 3 a compare write goes only to the buffer, and the working compare takes the buffer on the tick at count 255 (reached while rising, in mode 3).
- R9: A counter write loads the counter, and the counter does not advance in the write cycle. The first tick after the write produces no compare match: no flag, no output action and no clear-on-match.
- R10: A control write with bit 4 set, whose new mode is 0 or 1, applies the new output action to wave_o at that clock edge and does not set the compare flag. With a new mode of 2 or 3 the strobe has no effect.
- R11: Writing a flag bit as 1 clears that flag, and writing it as 0 leaves it unchanged. A flag event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| wave_o | output | 1 | Waveform output pin |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare flag |

## Verification
The embedded properties assume that a register write is a single-cycle strobe whose address and data are valid in that same cycle. They also assume that tick is a clean one-cycle enable, so that a counter write and a tick in the same cycle resolve in favour of the write. The bench drives every input at the falling edge as one-cycle pulses. It changes the mode only from a quiet state with no tick pending, and it never writes a counter value and expects an advance in the same cycle, which keeps every property's antecedent within those assumptions.

// File: rtl/ptm_pkg.sv
// Shared types and helpers for the PWM timer.
// Assumes the data path is at least 5 bits wide so the control word fits.
package ptm_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_CLRMATCH = 2'd1,
        MODE_SLOPE1   = 2'd2,
        MODE_SLOPE2   = 2'd3
    } ptm_mode_e;

    localparam logic [1:0] ADR_CTRL  = 2'd0;
    localparam logic [1:0] ADR_COUNT = 2'd1;
    localparam logic [1:0] ADR_CMP   = 2'd2;
    localparam logic [1:0] ADR_FLAG  = 2'd3;
    localparam int         FORCE_BIT = 4;

    // True for the two modes that buffer the compare value.
    function automatic logic mode_is_pwm(ptm_mode_e m);
        return m[1];
    endfunction

    // Output action used outside PWM: 1 toggle, 2 clear, 3 set, 0 hold.
    function automatic logic act_apply(logic [1:0] act, logic cur);
        case (act)
            2'd1:    return ~cur;
            2'd2:    return 1'b0;
            2'd3:    return 1'b1;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/ptm_regs.sv
// Register file: control word, compare buffer and sticky flags.
// Produces one-cycle write pulses for the counter and the compare path.
// Assumes wr_addr/wr_data are valid in the cycle wr_en is high.
module ptm_regs
    import ptm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic           ovf_evt,
    input  logic           cmp_evt,
    output ptm_mode_e      mode,
    output logic [1:0]     act,
    output logic [W-1:0]   cmp_buf,
    output logic           cnt_wr,
    output logic           cmp_wr,
    output logic           force_req,
    output logic [1:0]     force_act,
    output logic           ovf_flag,
    output logic           cmp_flag
);

    logic ctrl_wr;
    logic flag_wr;

    // Decode write strobes per address.
    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == ADR_CTRL);
        cnt_wr    = wr_en && (wr_addr == ADR_COUNT);
        cmp_wr    = wr_en && (wr_addr == ADR_CMP);
        flag_wr   = wr_en && (wr_addr == ADR_FLAG);
        force_act = wr_data[3:2];
        force_req = ctrl_wr && wr_data[FORCE_BIT]
                    && !mode_is_pwm(ptm_mode_e'(wr_data[1:0]));
    end

    // Control word and compare buffer storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_FREE;
            act     <= 2'd0;
            cmp_buf <= '0;
        end else begin
            if (ctrl_wr) begin
                mode <= ptm_mode_e'(wr_data[1:0]);
                act  <= wr_data[3:2];
            end
            if (cmp_wr) cmp_buf <= wr_data;
        end
    end

    // Sticky flags: an event sets, a written one clears, the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            if (ovf_evt)                    ovf_flag <= 1'b1;
            else if (flag_wr && wr_data[0]) ovf_flag <= 1'b0;
            if (cmp_evt)                    cmp_flag <= 1'b1;
            else if (flag_wr && wr_data[1]) cmp_flag <= 1'b0;
        end
    end

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && wr_data[0] && !ovf_evt) |=> !ovf_flag);          // R11
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> cmp_flag);                                       // R11

endmodule

// File: rtl/ptm_counter.sv
// Counter unit: advances on adv, in one of four count sequences.
// Emits wrap, top and bottom events and holds the one-tick match block
// that follows a counter write. Assumes adv is never high with cnt_wr.
module ptm_counter
    import ptm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ptm_mode_e    mode,
    input  logic         adv,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_val,
    input  logic         cmp_hit,
    output logic [W-1:0] cnt,
    output logic         down,
    output logic         blk,
    output logic         wrap_evt,
    output logic         top_evt,
    output logic         bottom_evt
);

    localparam logic [W-1:0] CMAX = {W{1'b1}};
    localparam logic [W-1:0] CMIN = '0;

    logic at_max;
    logic at_min;

    // Boundary detection and event strobes.
    always_comb begin
        at_max     = (cnt == CMAX);
        at_min     = (cnt == CMIN);
        wrap_evt   = adv && at_max && (mode != MODE_SLOPE2);
        top_evt    = adv && at_max && ((mode == MODE_SLOPE1)
                     || ((mode == MODE_SLOPE2) && !down));
        bottom_evt = adv && at_min && (mode == MODE_SLOPE2) && down;
    end

    // Count sequence, direction and write-block state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            down <= 1'b0;
            blk  <= 1'b0;
        end else begin
            if (mode != MODE_SLOPE2) down <= 1'b0;
            if (cnt_wr) begin
                cnt <= wr_val;
                blk <= 1'b1;
            end else if (adv) begin
                blk <= 1'b0;
                case (mode)
                    MODE_CLRMATCH: cnt <= cmp_hit ? CMIN : cnt + 1'b1;
                    MODE_SLOPE2: begin
                        if (!down) begin
                            if (at_max) begin
                                down <= 1'b1;
                                cnt  <= CMAX - 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end else begin
                            if (at_min) begin
                                down <= 1'b0;
                                cnt  <= CMIN + 1'b1;
                            end else begin
                                cnt <= cnt - 1'b1;
                            end
                        end
                    end
                    default: cnt <= cnt + 1'b1;
                endcase
            end
        end
    end

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode == MODE_FREE) |=> (cnt == W'($past(cnt) + 1'b1)));     // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cnt_wr) |=> $stable(cnt));                                // R2
    AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode == MODE_CLRMATCH && cmp_hit) |=> (cnt == CMIN));       // R3
    AST_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode == MODE_SLOPE2 && !down && at_max)
        |=> (down && cnt == CMAX - 1'b1));                                  // R5

endmodule

// File: rtl/ptm_wavegen.sv
// Compare unit and waveform generator: holds the working compare value,
// detects matches and computes the output pin per mode and action.
// Assumes force_req only arrives with a non-PWM new mode.
module ptm_wavegen
    import ptm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ptm_mode_e    mode,
    input  logic [1:0]   act,
    input  logic         adv,
    input  logic         blk,
    input  logic [W-1:0] cnt,
    input  logic         down,
    input  logic         cmp_wr,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cmp_buf,
    input  logic         top_evt,
    input  logic         wrap_evt,
    input  logic         force_req,
    input  logic [1:0]   force_act,
    output logic [W-1:0] cmp_act,
    output logic         cmp_hit,
    output logic         wave
);

    logic wave_d;

    // Match detection, suppressed for one tick after a counter write.
    always_comb cmp_hit = adv && !blk && (cnt == cmp_act);

    // Working compare: direct outside PWM, loaded at top inside PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cmp_act <= '0;
        else if (cmp_wr && !mode_is_pwm(mode)) cmp_act <= wr_val;
        else if (top_evt)                      cmp_act <= cmp_buf;
    end

    // Next output value from the force strobe or the mode and action.
    always_comb begin
        wave_d = wave;
        if (force_req) begin
            wave_d = act_apply(force_act, wave);
        end else begin
            case (mode)
                MODE_SLOPE1: begin
                    if (act == 2'd1 && cmp_hit)  wave_d = ~wave;
                    else if (act == 2'd2)        wave_d = wrap_evt ? 1'b1 : (cmp_hit ? 1'b0 : wave);
                    else if (act == 2'd3)        wave_d = wrap_evt ? 1'b0 : (cmp_hit ? 1'b1 : wave);
                end
                MODE_SLOPE2: begin
                    if (cmp_hit) begin
                        if (act == 2'd1)      wave_d = ~wave;
                        else if (act == 2'd2) wave_d = down;
                        else if (act == 2'd3) wave_d = ~down;
                    end
                end
                default: begin
                    if (cmp_hit) wave_d = act_apply(act, wave);
                end
            endcase
        end
    end

    // Output pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else        wave <= wave_d;
    end

    AST_BUFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_is_pwm(mode) && !top_evt) |=> $stable(cmp_act));             // R8
    AST_DISCONNECT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd0 && !force_req) |=> $stable(wave));                     // R7
    AST_FAST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLOPE1 && act == 2'd2 && wrap_evt && !force_req) |=> wave); // R4
    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd1 && cmp_hit && !force_req) |=> (wave != $past(wave)));  // R7

endmodule

// File: rtl/pwm_timer.sv
// Top level: an 8-bit timer with one compare channel and a waveform pin.
// Counts on an external clock-enable tick. A counter write in the same
// cycle as a tick takes priority and stops that tick's advance.
module pwm_timer
    import ptm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    output logic         wave_o,
    output logic         ovf_flag_o,
    output logic         cmp_flag_o
);

    ptm_mode_e    mode;
    logic [1:0]   act;
    logic [1:0]   force_act;
    logic [W-1:0] cmp_buf;
    logic [W-1:0] cmp_act;
    logic [W-1:0] cnt;
    logic         cnt_wr, cmp_wr, force_req;
    logic         adv, down, blk, cmp_hit;
    logic         wrap_evt, top_evt, bottom_evt, ovf_evt;

    // Advance only on ticks not taken over by a counter write.
    always_comb begin
        adv     = tick && !cnt_wr;
        ovf_evt = wrap_evt || bottom_evt;
    end

    ptm_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ovf_evt(ovf_evt), .cmp_evt(cmp_hit),
        .mode(mode), .act(act), .cmp_buf(cmp_buf), .cnt_wr(cnt_wr),
        .cmp_wr(cmp_wr), .force_req(force_req), .force_act(force_act),
        .ovf_flag(ovf_flag_o), .cmp_flag(cmp_flag_o)
    );

    ptm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mode(mode), .adv(adv), .cnt_wr(cnt_wr),
        .wr_val(wr_data), .cmp_hit(cmp_hit), .cnt(cnt), .down(down),
        .blk(blk), .wrap_evt(wrap_evt), .top_evt(top_evt),
        .bottom_evt(bottom_evt)
    );

    ptm_wavegen #(.W(W)) u_wave (
        .clk(clk), .rst_n(rst_n), .mode(mode), .act(act), .adv(adv),
        .blk(blk), .cnt(cnt), .down(down), .cmp_wr(cmp_wr),
        .wr_val(wr_data), .cmp_buf(cmp_buf), .top_evt(top_evt),
        .wrap_evt(wrap_evt), .force_req(force_req), .force_act(force_act),
        .cmp_act(cmp_act), .cmp_hit(cmp_hit), .wave(wave_o)
    );

    // Read multiplexer over the four word addresses.
    always_comb begin
        case (rd_addr)
            ADR_CTRL:  rd_data = {{(W-4){1'b0}}, act, mode};
            ADR_COUNT: rd_data = cnt;
            ADR_CMP:   rd_data = cmp_buf;
            default:   rd_data = {{(W-2){1'b0}}, cmp_flag_o, ovf_flag_o};
        endcase
    end

    AST_WRITE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && !cmp_flag_o) |=> !cmp_flag_o);                               // R9
    AST_FORCE_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req && !cmp_hit && !cmp_flag_o) |=> !cmp_flag_o);             // R10
    AST_BOTTOM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        bottom_evt |=> ovf_flag_o);                                          // R5
    AST_ACTIVE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_is_pwm(mode) && cmp_wr) |=> (cmp_act == cmp_buf));            // R3

endmodule

// File: tb/sim_pwm_timer.sv
`timescale 1ns/100ps
module sim_pwm_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       wave_o, ovf_flag_o, cmp_flag_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwm_timer #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wave_o(wave_o), .ovf_flag_o(ovf_flag_o),
        .cmp_flag_o(cmp_flag_o)
    );

    typedef struct packed {
        logic       t;
        logic       we;
        logic [1:0] a;
        logic [7:0] d;
        logic [1:0] ra;
        logic [7:0] ex;
        logic       w;
    } vec_t;

    // Clear-on-match run with toggle action, compare value 3.
    localparam vec_t VEC [0:14] = '{
        '{1'b0, 1'b1, 2'd0, 8'h05, 2'd0, 8'h05, 1'b0},  // R2 control readback
        '{1'b0, 1'b1, 2'd2, 8'h03, 2'd2, 8'h03, 1'b0},  // R3 compare write
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd1, 8'h01, 1'b0},
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd1, 8'h02, 1'b0},
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd1, 8'h03, 1'b0},
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd3, 8'h02, 1'b1},  // R3 match: flag, R7 toggle
        '{1'b0, 1'b0, 2'd0, 8'h00, 2'd1, 8'h00, 1'b1},  // R3 cleared to 0
        '{1'b0, 1'b1, 2'd3, 8'h02, 2'd3, 8'h00, 1'b1},  // R11 clear by one
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd1, 8'h01, 1'b1},
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd1, 8'h02, 1'b1},
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd1, 8'h03, 1'b1},
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd1, 8'h00, 1'b0},  // R7 second toggle
        '{1'b1, 1'b0, 2'd0, 8'h00, 2'd3, 8'h02, 1'b0},
        '{1'b0, 1'b1, 2'd3, 8'h00, 2'd3, 8'h02, 1'b0},  // R11 zero keeps
        '{1'b0, 1'b1, 2'd3, 8'h03, 2'd3, 8'h00, 1'b0}   // R11 clear both
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, settle after the rising edge.
    task automatic step(input logic t, input logic we, input logic [1:0] a,
                        input logic [7:0] d);
        @(negedge clk);
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        #0.5;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'h00);
    endtask

    // Count samples with the pin high over n ticks.
    task automatic duty(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 2'd0, 8'h00);
            if (wave_o) hi++;
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        int hi;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0.5;
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 count", v, 0);
        rd(2'd2, v); chk("R1 cmp", v, 0);
        rd(2'd3, v); chk("R1 flags", v, 0);
        chk("R1 wave", wave_o, 0);

        for (int k = 0; k < 15; k++) begin
            step(VEC[k].t, VEC[k].we, VEC[k].a, VEC[k].d);
            rd(VEC[k].ra, v);
            chk($sformatf("R3 vector %0d read", k), v, VEC[k].ex);
            chk($sformatf("R7 vector %0d wave", k), wave_o, VEC[k].w);
        end

        // R2 free count wrap, hold without tick; R7 action 0 holds pin
        step(1'b0, 1'b1, 2'd0, 8'h00);
        step(1'b0, 1'b1, 2'd1, 8'd254);
        step(1'b1, 1'b0, 2'd0, 8'h00);
        rd(2'd1, v); chk("R2 count 255", v, 255);
        step(1'b1, 1'b0, 2'd0, 8'h00);
        rd(2'd1, v); chk("R2 wrap to 0", v, 0);
        rd(2'd3, v); chk("R2 overflow flag", v, 1);
        step(1'b0, 1'b0, 2'd0, 8'h00);
        rd(2'd1, v); chk("R2 hold", v, 0);
        chk("R7 action 0 hold", wave_o, 0);
        step(1'b0, 1'b1, 2'd3, 8'h03);

        // R9 counter write blocks the next tick's match
        step(1'b0, 1'b1, 2'd0, 8'h05);
        step(1'b0, 1'b1, 2'd1, 8'd3);
        step(1'b1, 1'b1, 2'd1, 8'd3);
        rd(2'd1, v); chk("R9 write wins over tick", v, 3);
        step(1'b1, 1'b0, 2'd0, 8'h00);
        rd(2'd1, v); chk("R9 no clear after write", v, 4);
        rd(2'd3, v); chk("R9 no flag after write", v, 0);
        chk("R9 no toggle after write", wave_o, 0);
        step(1'b0, 1'b1, 2'd1, 8'd2);
        ticks(2);
        rd(2'd1, v); chk("R3 clear after match", v, 0);
        rd(2'd3, v); chk("R3 flag after match", v, 2);
        chk("R7 toggle", wave_o, 1);
        step(1'b0, 1'b1, 2'd3, 8'h03);

        // R10 force strobe
        step(1'b0, 1'b1, 2'd0, 8'h15);
        chk("R10 force toggle", wave_o, 0);
        rd(2'd3, v); chk("R10 no flag", v, 0);
        rd(2'd0, v); chk("R10 strobe reads 0", v, 8'h05);
        step(1'b0, 1'b1, 2'd0, 8'h1D);
        chk("R10 force set", wave_o, 1);
        step(1'b0, 1'b1, 2'd0, 8'h1A);
        chk("R10 ignored in PWM", wave_o, 1);
        rd(2'd3, v); chk("R10 ignored no flag", v, 0);

        // R8 buffered compare in single-slope PWM, R4 duty
        step(1'b0, 1'b1, 2'd2, 8'd200);
        rd(2'd2, v); chk("R8 buffer readback", v, 200);
        step(1'b0, 1'b1, 2'd1, 8'd10);
        ticks(245);
        rd(2'd1, v); chk("R4 reach 255", v, 255);
        rd(2'd3, v); chk("R8 no early match", v, 0);
        step(1'b1, 1'b0, 2'd0, 8'h00);
        rd(2'd3, v); chk("R4 overflow at wrap", v, 1);
        chk("R4 set at wrap", wave_o, 1);
        ticks(201);
        rd(2'd3, v); chk("R8 match on new value", v, 3);
        duty(256, hi); chk("R4 non-inverted duty", hi, 201);
        step(1'b0, 1'b1, 2'd0, 8'h0E);
        ticks(256);
        duty(256, hi); chk("R4 inverted duty", hi, 55);

        // R5 dual slope, R6 duty
        step(1'b0, 1'b1, 2'd0, 8'h0B);
        step(1'b0, 1'b1, 2'd2, 8'd64);
        step(1'b0, 1'b1, 2'd1, 8'd0);
        step(1'b0, 1'b1, 2'd3, 8'h03);
        ticks(255);
        rd(2'd1, v); chk("R5 rise to 255", v, 255);
        step(1'b1, 1'b0, 2'd0, 8'h00);
        rd(2'd1, v); chk("R5 turn at top", v, 254);
        ticks(254);
        rd(2'd1, v); chk("R5 fall to 0", v, 0);
        rd(2'd3, v); chk("R5 no overflow before bottom", v & 1, 0);
        step(1'b1, 1'b0, 2'd0, 8'h00);
        rd(2'd1, v); chk("R5 turn at bottom", v, 1);
        rd(2'd3, v); chk("R5 overflow at bottom", v & 1, 1);
        duty(510, hi); chk("R6 dual-slope duty", hi, 128);

        summary();
    end

endmodule